// File: doc/BRIEF.md
# Port-Write Unlock Sequence Detector

This block watches byte writes aimed at one 8-bit I/O port and compares them, write by write, against a fixed unlock sequence. The sequence starts with a two-byte synchronisation pair (0xFF, then 0x00). It continues with a run of bytes that an internal 8-bit two-tap XOR generator produces on the fly, starting from a seed. The write that follows the last generated byte is a key byte. The value 0xCD sets an "unlocked" flag, and any other value clears it.

The flag does one thing only. It gates the write-enable of an extra control register that sits beside the other registers of the same controller. Clearing the flag again leaves that register's current contents alone and only blocks new writes to it. Writes to other ports, and cycles with no write strobe, never disturb progress through the sequence.

Top module: `ulk_port_unlock`

## Requirements
- R1: While `rst_n` is low at a clock edge, `unlocked` becomes 0 and the detector returns to hunting for the synchronisation pair. The reset is synchronous and active low.
- R2: A write is examined only when `io_wr` is 1 and `io_addr_hi` equals 0xBC. Any other write, or a cycle with `io_wr` at 0, leaves the progress of the sequence unchanged.
- R3: The sequence opens with 0xFF followed by 0x00. Further 0xFF bytes written before the 0x00 keep the detector armed.
- R4: After the pair, 13 generated bytes must follow in order: FF,77,B3,51,A8,D4,62,39,9C,46,2B,15,8A. Each byte after the first is derived from the previous one. New bit 7 is old bit 7 XOR old bit 4. New bits 6..4 are old bits 7..5. New bit 3 is old bit 1 XOR old bit 0. New bits 2..0 are old bits 3..1.
- R5: A key byte of 0xCD on the examined write that directly follows 0x8A sets `unlocked`. The flag changes at the clock edge that samples the key write, so it is visible one clock after the strobe and not during it.
- R6: A key byte of any value other than 0xCD clears `unlocked`, which re-locks the block.
- R7: A byte that does not match the expected value aborts the check. A mismatching 0xFF is taken as the first byte of a new pair. Any other mismatching byte returns the detector to hunting.
- R8: Only the single examined write after the last generated byte is treated as a key. After it, the detector hunts again, and a later 0xCD on its own has no effect on `unlocked`.
- R9: `xreg_wr_en` equals `xreg_wr_req` AND `unlocked`. It is combinational, so it follows the request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr_hi | input | 8 | High byte of the I/O address of the write |
| io_wdata | input | 8 | Data byte of the write |
| xreg_wr_req | input | 1 | Request to write the gated extra register |
| unlocked | output | 1 | Unlock flag |
| xreg_wr_en | output | 1 | Write-enable for the gated extra register |

## Verification
Each sequence or key write is driven for exactly one cycle. The bench samples `unlocked` at the falling edge after the rising edge that took the write. That is the first point where R5 and R6 place a change, and a check just before that edge confirms the flag has not yet moved. `xreg_wr_en` is combinational, so it is checked a short delay after `xreg_wr_req` changes, within the same cycle. Seeded random writes are mostly the byte the next step expects, mixed with foreign ports, idle strobes and stray bytes. They are scored after every write against a bench model built from the requirements, while directed runs cover re-arming, aborts and stray key bytes.

// File: rtl/ulk_pkg.sv
// Package: shared state encoding and the expected-byte generator step.
// Assumes 8-bit data; the tap positions are fixed by the unlock protocol.
package ulk_pkg;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_KEY   = 2'd3
    } ulk_state_e;

    // One step of the two-tap XOR generator: shift each nibble right, refill top bits.
    function automatic logic [7:0] ulk_next(input logic [7:0] b);
        return {b[7] ^ b[4], b[7:5], b[1] ^ b[0], b[3:1]};
    endfunction

endpackage

// File: rtl/ulk_expect_gen.sv
// Expected-byte generator: holds the byte the run expects next and its index.
// Assumes load and adv are never high together (the sequencer guarantees it).
module ulk_expect_gen #(
    parameter logic [7:0] SEED    = 8'hFF,
    parameter int         RUN_LEN = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       adv,
    output logic [7:0] exp_byte,
    output logic       last
);
    import ulk_pkg::*;

    localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(RUN_LEN - 1);

    logic [CW-1:0] idx;

    // Reload the seed on a fresh pair, step the generator on each matched byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_byte <= SEED;
            idx      <= '0;
        end else if (load) begin
            exp_byte <= SEED;
            idx      <= '0;
        end else if (adv && (idx != LAST_IDX)) begin
            exp_byte <= ulk_next(exp_byte);
            idx      <= idx + 1'b1;
        end
    end

    // Flag the final byte of the generated run.
    always_comb last = (idx == LAST_IDX);

    a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);

    a_r4_seed_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (exp_byte == SEED) && (idx == '0));

endmodule

// File: rtl/ulk_seq_fsm.sv
// Sequencer: walks sync pair, generated run and key slot on examined writes.
// Assumes hit is a single-cycle qualifier for one examined port write.
module ulk_seq_fsm #(
    parameter logic [7:0] SYNC_LEAD  = 8'hFF,
    parameter logic [7:0] SYNC_TRAIL = 8'h00,
    parameter logic [7:0] KEY        = 8'hCD
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [7:0] data,
    input  logic [7:0] exp_byte,
    input  logic       last,
    output logic       load,
    output logic       adv,
    output logic       key_valid,
    output logic       key_ok
);
    import ulk_pkg::*;

    ulk_state_e state, state_nx;

    // Next-state and strobe decode for one examined write.
    always_comb begin
        state_nx  = state;
        load      = 1'b0;
        adv       = 1'b0;
        key_valid = 1'b0;
        key_ok    = 1'b0;
        if (hit) begin
            unique case (state)
                ST_HUNT: begin
                    if (data == SYNC_LEAD) state_nx = ST_ARMED;
                end
                ST_ARMED: begin
                    if (data == SYNC_TRAIL) begin
                        load     = 1'b1;
                        state_nx = ST_RUN;
                    end else if (data != SYNC_LEAD) begin
                        state_nx = ST_HUNT;
                    end
                end
                ST_RUN: begin
                    if (data == exp_byte) begin
                        adv = 1'b1;
                        if (last) state_nx = ST_KEY;
                    end else if (data == SYNC_LEAD) begin
                        state_nx = ST_ARMED;
                    end else begin
                        state_nx = ST_HUNT;
                    end
                end
                ST_KEY: begin
                    key_valid = 1'b1;
                    key_ok    = (data == KEY);
                    state_nx  = ST_HUNT;
                end
                default: state_nx = ST_HUNT;
            endcase
        end
    end

    // State register with synchronous reset to hunting.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(state));

    a_r3_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RUN) |-> $past(state == ST_ARMED) && $past(data) == SYNC_TRAIL);

    a_r8_key_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_KEY) |-> $past(state == ST_RUN) && $past(hit));

    a_r8_key_once: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> (state == ST_HUNT));

endmodule

// File: rtl/ulk_lock_flag.sv
// Lock flag: captures the key verdict; holds otherwise.
// Assumes key_valid marks the single key-slot write.
module ulk_lock_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic key_valid,
    input  logic key_ok,
    output logic unlocked
);
    // Set on a correct key, clear on any other key, hold between keys.
    always_ff @(posedge clk) begin
        if (!rst_n)         unlocked <= 1'b0;
        else if (key_valid) unlocked <= key_ok;
    end

    a_r5_key_update: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> unlocked == $past(key_ok));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |=> $stable(unlocked));

endmodule

// File: rtl/ulk_port_unlock.sv
// Top: qualifies writes to the watched port, runs the unlock check and
// gates the extra register's write-enable. Assumes one cycle per write.
module ulk_port_unlock #(
    parameter logic [7:0] PORT_HI    = 8'hBC,
    parameter logic [7:0] SYNC_LEAD  = 8'hFF,
    parameter logic [7:0] SYNC_TRAIL = 8'h00,
    parameter logic [7:0] SEED       = 8'hFF,
    parameter int         RUN_LEN    = 13,
    parameter logic [7:0] KEY        = 8'hCD
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr,
    input  logic [7:0] io_addr_hi,
    input  logic [7:0] io_wdata,
    input  logic       xreg_wr_req,
    output logic       unlocked,
    output logic       xreg_wr_en
);
    logic       hit;
    logic       load, adv, last, key_valid, key_ok;
    logic [7:0] exp_byte;

    // Examine only strobed writes to the watched port.
    always_comb hit = io_wr && (io_addr_hi == PORT_HI);

    ulk_expect_gen #(
        .SEED    (SEED),
        .RUN_LEN (RUN_LEN)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .exp_byte (exp_byte),
        .last     (last)
    );

    ulk_seq_fsm #(
        .SYNC_LEAD  (SYNC_LEAD),
        .SYNC_TRAIL (SYNC_TRAIL),
        .KEY        (KEY)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .data      (io_wdata),
        .exp_byte  (exp_byte),
        .last      (last),
        .load      (load),
        .adv       (adv),
        .key_valid (key_valid),
        .key_ok    (key_ok)
    );

    ulk_lock_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_ok    (key_ok),
        .unlocked  (unlocked)
    );

    // Gate extra-register writes on the flag, no added latency.
    always_comb xreg_wr_en = xreg_wr_req && unlocked;

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !unlocked);

    a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
        xreg_wr_en |-> unlocked && xreg_wr_req);

    a_r2_foreign_no_key: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(unlocked));

endmodule

// File: tb/ulk_port_unlock_bench.sv
`timescale 1ns/1ps
module ulk_port_unlock_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_addr_hi = 8'h00;
    logic [7:0] io_wdata = 8'h00;
    logic       xreg_wr_req = 1'b0;
    logic       unlocked;
    logic       xreg_wr_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state: 0 hunt, 1 armed, 2 run, 3 key slot
    int         m_st = 0;
    int         m_i = 0;
    logic [7:0] m_e = 8'hFF;
    logic       m_unl = 1'b0;

    logic [7:0] run_bytes [13] = '{8'hFF, 8'h77, 8'hB3, 8'h51, 8'hA8, 8'hD4, 8'h62,
                                   8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15, 8'h8A};

    always #2.5 clk = ~clk;

    ulk_port_unlock u_ulk_port_unlock (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_wr       (io_wr),
        .io_addr_hi  (io_addr_hi),
        .io_wdata    (io_wdata),
        .xreg_wr_req (xreg_wr_req),
        .unlocked    (unlocked),
        .xreg_wr_en  (xreg_wr_en)
    );

    function automatic logic [7:0] gen_next(input logic [7:0] b);
        logic [7:0] n;
        n[7]   = b[7] ^ b[4];
        n[6:4] = b[7:5];
        n[3]   = b[1] ^ b[0];
        n[2:0] = b[3:1];
        return n;
    endfunction

    function automatic logic [7:0] model_want();
        case (m_st)
            0: return 8'hFF;
            1: return 8'h00;
            2: return m_e;
            default: return ($urandom % 2) ? 8'hCD : 8'($urandom);
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_step(input logic [7:0] d);
        case (m_st)
            0: if (d == 8'hFF) m_st = 1;
            1: begin
                if (d == 8'h00) begin m_st = 2; m_i = 0; m_e = 8'hFF; end
                else if (d != 8'hFF) m_st = 0;
            end
            2: begin
                if (d == m_e) begin
                    if (m_i == 12) m_st = 3;
                    else begin m_i++; m_e = gen_next(m_e); end
                end else if (d == 8'hFF) m_st = 1;
                else m_st = 0;
            end
            default: begin m_unl = (d == 8'hCD); m_st = 0; end
        endcase
    endtask

    // one-cycle write, then score the flag against the model
    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        io_wr = 1'b1; io_addr_hi = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        if (a == 8'hBC) model_step(d);
        chk(unlocked == m_unl, req, unlocked, m_unl);
    endtask

    task automatic idle_cycle(input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b0; io_addr_hi = 8'hBC; io_wdata = d;
    endtask

    task automatic run_seq(input bit with_noise, input string req);
        wr(8'hBC, 8'hFF, req);
        wr(8'hBC, 8'h00, req);
        for (int k = 0; k < 13; k++) begin
            if (with_noise) begin
                wr(8'h7F, 8'hCD, "R2");
                idle_cycle(8'h00);
            end
            wr(8'hBC, run_bytes[k], req);
        end
    endtask

    task automatic req_check(input string req);
        @(negedge clk);
        xreg_wr_req = 1'b1;
        #1;
        chk(xreg_wr_en == unlocked, req, xreg_wr_en, unlocked);
        xreg_wr_req = 1'b0;
        #1;
        chk(xreg_wr_en == 1'b0, req, xreg_wr_en, 0);
    endtask

    // watchdog: ends a hung run as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(unlocked == 1'b0, "R1 reset", unlocked, 0);
        req_check("R9 locked");

        // R4/R5: clean run and key, flag late by one clock
        run_seq(1'b0, "R4");
        chk(unlocked == 1'b0, "R4 before key", unlocked, 0);
        @(negedge clk);
        io_wr = 1'b1; io_addr_hi = 8'hBC; io_wdata = 8'hCD;
        #1;
        chk(unlocked == 1'b0, "R5 not during strobe", unlocked, 0);
        @(negedge clk);
        io_wr = 1'b0;
        model_step(8'hCD);
        chk(unlocked == 1'b1, "R5 set", unlocked, 1);
        req_check("R9 unlocked");

        // R8: a stray CD outside the key slot changes nothing
        wr(8'hBC, 8'hCD, "R8");
        chk(unlocked == 1'b1, "R8 stray key", unlocked, 1);

        // R6: wrong key re-locks
        run_seq(1'b0, "R4");
        wr(8'hBC, 8'h00, "R6");
        chk(unlocked == 1'b0, "R6 relock", unlocked, 0);
        wr(8'hBC, 8'hCD, "R8 late key");
        chk(unlocked == 1'b0, "R8 late key", unlocked, 0);

        // R2: foreign ports and idle cycles between sequence bytes
        run_seq(1'b1, "R2");
        wr(8'hBC, 8'hCD, "R2");
        chk(unlocked == 1'b1, "R2 noisy unlock", unlocked, 1);
        run_seq(1'b0, "R6");
        wr(8'hBC, 8'h42, "R6");

        // R7: mismatch mid-run aborts; rest of run then key does not unlock
        wr(8'hBC, 8'hFF, "R7");
        wr(8'hBC, 8'h00, "R7");
        for (int k = 0; k < 5; k++) wr(8'hBC, run_bytes[k], "R7");
        wr(8'hBC, 8'h11, "R7");
        for (int k = 5; k < 13; k++) wr(8'hBC, run_bytes[k], "R7");
        wr(8'hBC, 8'hCD, "R7");
        chk(unlocked == 1'b0, "R7 abort", unlocked, 0);

        // R7: mismatching FF re-arms, so 00 + run + key unlocks
        wr(8'hBC, 8'hFF, "R7");
        wr(8'hBC, 8'h00, "R7");
        for (int k = 0; k < 7; k++) wr(8'hBC, run_bytes[k], "R7");
        wr(8'hBC, 8'hFF, "R7");
        wr(8'hBC, 8'h00, "R7");
        for (int k = 0; k < 13; k++) wr(8'hBC, run_bytes[k], "R7");
        wr(8'hBC, 8'hCD, "R7");
        chk(unlocked == 1'b1, "R7 rearm", unlocked, 1);

        // R3: repeated leading FF keeps armed
        wr(8'hBC, 8'h05, "R3");
        for (int k = 0; k < 4; k++) wr(8'hBC, 8'hFF, "R3");
        wr(8'hBC, 8'h00, "R3");
        for (int k = 0; k < 13; k++) wr(8'hBC, run_bytes[k], "R3");
        wr(8'hBC, 8'h99, "R3");
        chk(unlocked == 1'b0, "R3 multi FF then relock", unlocked, 0);

        // R4: bench generator agrees with the listed run
        begin
            logic [7:0] g = 8'hFF;
            for (int k = 0; k < 13; k++) begin
                chk(g == run_bytes[k], "R4 table", g, run_bytes[k]);
                g = gen_next(g);
            end
        end

        // R1: reset mid-sequence clears flag and progress
        run_seq(1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_unl = 1'b0;
        wr(8'hBC, 8'hCD, "R1 after reset");
        chk(unlocked == 1'b0, "R1 progress cleared", unlocked, 0);

        // random mix scored against the model
        for (int n = 0; n < 6000; n++) begin
            int kind = int'($urandom % 20);
            if (kind == 0) begin
                idle_cycle(8'($urandom));
            end else if (kind == 1) begin
                req_check("R9 random");
            end else if (kind < 4) begin
                wr(8'($urandom % 255), 8'($urandom), "R2 random");
            end else if (($urandom % 100) < 92) begin
                wr(8'hBC, model_want(), "R5/R6 random");
            end else begin
                wr(8'hBC, 8'($urandom), "R7 random");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule